// File: doc/BRIEF.md
# Read-Modify-Write Shift Combine Unit

This block is the execution stage for the read-modify-write group of an 8-bit accumulator processor. The sequencer that fetches the memory operand presents it to the unit together with the accumulator, the incoming status flags and an operation select. One cycle later the unit returns three things: the byte to write back to memory, the new accumulator value, and the updated carry, overflow, negative and zero flags.

The unit implements plain shifts and rotates, which leave the accumulator untouched. It also implements fused operations. In these, the modified memory byte is then ORed, ANDed or XORed into the accumulator, or added to it or subtracted from it in binary arithmetic. Addressing, bus timing and decimal arithmetic belong to the surrounding core.

An operation is accepted when `inValid` and `inReady` are both high at a rising clock edge. The result registers load on that edge and hold until the next accepted operation.

Top module: `rmw_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `inReady`, `outByte`, `outAcc` and all four flag outputs are 0. From the first clock edge after reset is released, `inReady` is 1.
- R2: `outValid` is high for exactly the one cycle that follows an accepted operation, and low in every other cycle.
- R3: Select 0 shifts the operand left, filling bit 0 with zero and moving bit 7 to carry. Select 1 shifts it right, filling bit 7 with zero and moving bit 0 to carry. N and Z come from the written byte, the accumulator passes through unchanged, and overflow is unchanged.
- R4: Select 2 rotates left through carry (new bit 0 is the old carry, new carry is old bit 7). Select 3 rotates right through carry (new bit 7 is the old carry, new carry is old bit 0). N and Z come from the written byte, and the accumulator and overflow are unchanged.
- R5: Select 4 writes back the left-shifted operand, with old bit 7 going to carry, and the accumulator becomes accumulator OR written byte. N and Z come from the new accumulator.
- R6: Select 5 writes back the rotated-left byte, with carry set as in R4, and the accumulator becomes accumulator AND written byte. N and Z come from the new accumulator.
- R7: Select 6 writes back the right-shifted operand, with old bit 0 going to carry, and the accumulator becomes accumulator XOR written byte. N and Z come from the new accumulator.
- R8: Select 7 writes back the rotated-right byte. The accumulator becomes accumulator + written byte + the carry produced by the rotation, modulo 256. Carry is bit 8 of that 9-bit sum. Overflow is set when both addends have the same bit 7 and the result's bit 7 differs from it. N and Z come from the new accumulator.
- R9: Select 8 writes back operand + 1 (modulo 256). The accumulator becomes accumulator − written byte − (1 − carry in), modulo 256. Carry is 1 when no borrow occurred. Overflow is set when the accumulator and the written byte differ in bit 7 and the result's bit 7 differs from the accumulator's. N and Z come from the new accumulator.
- R10: Selects 9 to 15 write back the operand unchanged and pass the accumulator and all four incoming flags through unchanged.
- R11: When no operation is accepted, all result outputs keep their values regardless of input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation presented this cycle |
| inReady | output | 1 | Unit can accept an operation |
| opSel | input | 4 | Operation select (encoding in R3 to R10) |
| operand | input | DATA_W | Memory byte read by the core |
| accIn | input | DATA_W | Current accumulator |
| carryIn | input | 1 | Current carry flag |
| ovfIn | input | 1 | Current overflow flag |
| negIn | input | 1 | Current negative flag |
| zeroIn | input | 1 | Current zero flag |
| outValid | output | 1 | Result strobe, one cycle |
| outByte | output | DATA_W | Byte to write back to memory |
| outAcc | output | DATA_W | New accumulator |
| outCarry | output | 1 | New carry flag |
| outOvf | output | 1 | New overflow flag |
| outNeg | output | 1 | New negative flag |
| outZero | output | 1 | New zero flag |

## Verification
The bench builds the unit with the default `DATA_W` of 8, the width the flag rules are written for. At this width the increment wraps from 0xFF to 0x00, and the signed boundary at 0x7F/0x80 drives the overflow cases of both the add and the subtract paths. Shift and rotate patterns of 0x80 and 0x01 send the lost bit into carry and, with a suitable carry in, produce a zero result that sets Z.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    OP_SHL       = 4'd0,
    OP_SHR       = 4'd1,
    OP_ROTL      = 4'd2,
    OP_ROTR      = 4'd3,
    OP_SHL_OR    = 4'd4,
    OP_ROTL_AND  = 4'd5,
    OP_SHR_XOR   = 4'd6,
    OP_ROTR_ADD  = 4'd7,
    OP_INC_SUB   = 4'd8
  } op_e;

  localparam logic [3:0] LAST_OP = 4'd8;

  typedef enum logic [1:0] {
    MOD_PASS,
    MOD_LEFT,
    MOD_RIGHT,
    MOD_INC
  } mod_e;

  typedef enum logic [2:0] {
    ACC_KEEP,
    ACC_OR,
    ACC_AND,
    ACC_XOR,
    ACC_ADD,
    ACC_SUB
  } acc_e;

  typedef struct packed {
    logic load;
    mod_e modKind;
    logic rotate;
    acc_e accKind;
    logic flagsFromAcc;
    logic touchFlags;
  } ctl_t;

endpackage

// File: rtl/rmw_ctl.sv
module rmw_ctl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] opSel,
  output logic       inReady,
  output logic       outValid,
  output ctl_t       ctl
);

  logic accept;
  assign accept = inValid & inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReady  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      inReady  <= 1'b1;
      outValid <= accept;
    end
  end

  always_comb begin
    ctl              = '0;
    ctl.load         = accept;
    ctl.modKind      = MOD_PASS;
    ctl.accKind      = ACC_KEEP;
    ctl.touchFlags   = 1'b1;
    case (opSel)
      OP_SHL:      ctl.modKind = MOD_LEFT;
      OP_SHR:      ctl.modKind = MOD_RIGHT;
      OP_ROTL:     begin ctl.modKind = MOD_LEFT;  ctl.rotate = 1'b1; end
      OP_ROTR:     begin ctl.modKind = MOD_RIGHT; ctl.rotate = 1'b1; end
      OP_SHL_OR:   begin ctl.modKind = MOD_LEFT;  ctl.accKind = ACC_OR;  ctl.flagsFromAcc = 1'b1; end
      OP_ROTL_AND: begin ctl.modKind = MOD_LEFT;  ctl.rotate = 1'b1; ctl.accKind = ACC_AND; ctl.flagsFromAcc = 1'b1; end
      OP_SHR_XOR:  begin ctl.modKind = MOD_RIGHT; ctl.accKind = ACC_XOR; ctl.flagsFromAcc = 1'b1; end
      OP_ROTR_ADD: begin ctl.modKind = MOD_RIGHT; ctl.rotate = 1'b1; ctl.accKind = ACC_ADD; ctl.flagsFromAcc = 1'b1; end
      OP_INC_SUB:  begin ctl.modKind = MOD_INC;   ctl.accKind = ACC_SUB; ctl.flagsFromAcc = 1'b1; end
      default:     ctl.touchFlags = 1'b0;
    endcase
  end

endmodule

// File: rtl/rmw_dp.sv
module rmw_dp
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              negIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] outByte,
  output logic [DATA_W-1:0] outAcc,
  output logic              outCarry,
  output logic              outOvf,
  output logic              outNeg,
  output logic              outZero
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] modByte, addend, newAcc, nzSrc;
  logic              modCarry, fillBit, arith, newCarry, newOvf;
  logic [DATA_W:0]   sum;

  assign fillBit = ctl.rotate & carryIn;

  // memory-side modification
  always_comb begin
    case (ctl.modKind)
      MOD_LEFT:  begin modByte = {operand[MSB-1:0], fillBit}; modCarry = operand[MSB]; end
      MOD_RIGHT: begin modByte = {fillBit, operand[MSB:1]};   modCarry = operand[0];   end
      MOD_INC:   begin modByte = operand + 1'b1;              modCarry = carryIn;      end
      default:   begin modByte = operand;                     modCarry = carryIn;      end
    endcase
  end

  // shared adder: subtract is add of the inverted byte with carry as not-borrow
  assign arith  = (ctl.accKind == ACC_ADD) || (ctl.accKind == ACC_SUB);
  assign addend = (ctl.accKind == ACC_SUB) ? ~modByte : modByte;
  assign sum    = {1'b0, accIn} + {1'b0, addend} + {{DATA_W{1'b0}}, modCarry};

  always_comb begin
    case (ctl.accKind)
      ACC_OR:  newAcc = accIn | modByte;
      ACC_AND: newAcc = accIn & modByte;
      ACC_XOR: newAcc = accIn ^ modByte;
      ACC_ADD,
      ACC_SUB: newAcc = sum[MSB:0];
      default: newAcc = accIn;
    endcase
  end

  assign newCarry = arith ? sum[DATA_W] : modCarry;
  assign newOvf   = arith ? ((accIn[MSB] == addend[MSB]) && (sum[MSB] != accIn[MSB])) : ovfIn;
  assign nzSrc    = ctl.flagsFromAcc ? newAcc : modByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte  <= '0;
      outAcc   <= '0;
      outCarry <= 1'b0;
      outOvf   <= 1'b0;
      outNeg   <= 1'b0;
      outZero  <= 1'b0;
    end else if (ctl.load) begin
      outByte  <= modByte;
      outAcc   <= newAcc;
      outCarry <= ctl.touchFlags ? newCarry    : carryIn;
      outOvf   <= ctl.touchFlags ? newOvf      : ovfIn;
      outNeg   <= ctl.touchFlags ? nzSrc[MSB]  : negIn;
      outZero  <= ctl.touchFlags ? (nzSrc == '0) : zeroIn;
    end
  end

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              negIn,
  input  logic              zeroIn,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic [DATA_W-1:0] outAcc,
  output logic              outCarry,
  output logic              outOvf,
  output logic              outNeg,
  output logic              outZero
);

  ctl_t ctl;

  rmw_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  rmw_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .operand  (operand),
    .accIn    (accIn),
    .carryIn  (carryIn),
    .ovfIn    (ovfIn),
    .negIn    (negIn),
    .zeroIn   (zeroIn),
    .outByte  (outByte),
    .outAcc   (outAcc),
    .outCarry (outCarry),
    .outOvf   (outOvf),
    .outNeg   (outNeg),
    .outZero  (outZero)
  );

endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] accIn,
  input logic              carryIn,
  input logic              outValid,
  input logic [DATA_W-1:0] outByte,
  input logic [DATA_W-1:0] outAcc,
  input logic              outCarry
);

  logic accept;
  assign accept = inValid && inReady;

  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);  // R2
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !outValid);  // R2
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel == OP_SHL) |=> (outCarry == $past(operand[DATA_W-1])) && (outAcc == $past(accIn)));  // R3
  AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel == OP_SHR) |=> (outByte[DATA_W-1] == 1'b0) && (outCarry == $past(operand[0])));  // R3
  AST_INC_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel == OP_INC_SUB) |=> (outByte == $past(operand) + 1'b1));  // R9
  AST_UNSUPPORTED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opSel > LAST_OP) |=> (outByte == $past(operand)) && (outAcc == $past(accIn)) && (outCarry == $past(carryIn)));  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(outByte) && $stable(outAcc) && $stable(outCarry));  // R11

endmodule

bind rmw_unit rmw_unit_chk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .opSel    (opSel),
  .operand  (operand),
  .accIn    (accIn),
  .carryIn  (carryIn),
  .outValid (outValid),
  .outByte  (outByte),
  .outAcc   (outAcc),
  .outCarry (outCarry)
);

// File: tb/sim_rmw_unit.sv
`timescale 1ns/1ps
module sim_rmw_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [3:0] opSel = '0;
  logic [7:0] operand = '0, accIn = '0;
  logic       carryIn = 1'b0, ovfIn = 1'b0, negIn = 1'b0, zeroIn = 1'b0;
  logic       outValid;
  logic [7:0] outByte, outAcc;
  logic       outCarry, outOvf, outNeg, outZero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rmw_unit #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .opSel(opSel),
    .operand(operand), .accIn(accIn), .carryIn(carryIn), .ovfIn(ovfIn),
    .negIn(negIn), .zeroIn(zeroIn), .outValid(outValid), .outByte(outByte),
    .outAcc(outAcc), .outCarry(outCarry), .outOvf(outOvf), .outNeg(outNeg),
    .outZero(outZero)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {byte, acc, carry, ovf, neg, zero} from the requirement text
  function automatic logic [19:0] model(int op, int a, int m, int c, int v, int n, int z);
    int b, na, nc, nv, d;
    bit fromAcc;
    b = m; na = a; nc = c; nv = v; fromAcc = 0;
    case (op)
      0: begin b = (m << 1) & 255; nc = (m >> 7) & 1; end
      1: begin b = m >> 1; nc = m & 1; end
      2: begin b = ((m << 1) | c) & 255; nc = (m >> 7) & 1; end
      3: begin b = (m >> 1) | (c << 7); nc = m & 1; end
      4: begin b = (m << 1) & 255; nc = (m >> 7) & 1; na = a | b; fromAcc = 1; end
      5: begin b = ((m << 1) | c) & 255; nc = (m >> 7) & 1; na = a & b; fromAcc = 1; end
      6: begin b = m >> 1; nc = m & 1; na = a ^ b; fromAcc = 1; end
      7: begin
        b = (m >> 1) | (c << 7); d = a + b + (m & 1);
        na = d & 255; nc = (d >> 8) & 1;
        nv = (((a ^ b) & 128) == 0 && ((a ^ d) & 128) != 0) ? 1 : 0;
        fromAcc = 1;
      end
      8: begin
        b = (m + 1) & 255; d = a - b - (1 - c);
        na = d & 255; nc = (d >= 0) ? 1 : 0;
        nv = (((a ^ b) & 128) != 0 && ((a ^ d) & 128) != 0) ? 1 : 0;
        fromAcc = 1;
      end
      default: ;
    endcase
    if (op <= 8) begin
      if (fromAcc) begin n = (na >> 7) & 1; z = (na == 0) ? 1 : 0; end
      else         begin n = (b >> 7) & 1;  z = (b == 0) ? 1 : 0; end
    end
    model = {b[7:0], na[7:0], nc[0], nv[0], n[0], z[0]};
  endfunction

  task automatic runOp(string req, int op, int a, int m, int c, int v, int n, int z);
    @(negedge clk);
    opSel = op[3:0]; accIn = a[7:0]; operand = m[7:0];
    carryIn = c[0]; ovfIn = v[0]; negIn = n[0]; zeroIn = z[0];
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " strobe R2"}, outValid, 1);
    check(req, {outByte, outAcc, outCarry, outOvf, outNeg, outZero}, model(op, a, m, c, v, n, z));
    @(negedge clk);
    check({req, " strobe drop R2"}, outValid, 0);
  endtask

  task automatic tReset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {outValid, inReady, outByte, outAcc, outCarry, outOvf, outNeg, outZero}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", inReady, 1);
    check("R2 idle no strobe", outValid, 0);
  endtask

  task automatic tShifts;
    runOp("R3 shl 0x80", 0, 8'h11, 8'h80, 0, 1, 0, 0);
    runOp("R3 shl 0x41", 0, 8'h22, 8'h41, 1, 0, 0, 0);
    runOp("R3 shr 0x01", 1, 8'h33, 8'h01, 1, 0, 1, 0);
    runOp("R3 shr 0xFE", 1, 8'h44, 8'hFE, 0, 1, 0, 1);
  endtask

  task automatic tRotates;
    runOp("R4 rotl c1", 2, 8'h00, 8'h80, 1, 0, 0, 0);
    runOp("R4 rotl c0 zero", 2, 8'h00, 8'h80, 0, 0, 0, 0);
    runOp("R4 rotr c1", 3, 8'h55, 8'h01, 1, 0, 0, 0);
    runOp("R4 rotr c0", 3, 8'h55, 8'hAA, 0, 1, 0, 0);
  endtask

  task automatic tLogic;
    runOp("R5 shl or", 4, 8'h0F, 8'hC3, 0, 0, 0, 0);
    runOp("R5 shl or zero", 4, 8'h00, 8'h80, 0, 1, 0, 0);
    runOp("R6 rotl and", 5, 8'hF0, 8'h78, 1, 0, 0, 0);
    runOp("R6 rotl and zero", 5, 8'h0F, 8'hF0, 0, 0, 0, 0);
    runOp("R7 shr xor", 6, 8'hFF, 8'h03, 0, 0, 0, 0);
    runOp("R7 shr xor zero", 6, 8'h40, 8'h81, 0, 0, 0, 0);
  endtask

  task automatic tAdd;
    runOp("R8 add plain", 7, 8'h10, 8'h20, 0, 1, 0, 0);
    runOp("R8 add ovf", 7, 8'h7F, 8'h01, 0, 0, 0, 0);   // byte 0x00, carry 1 -> 0x80, V=1
    runOp("R8 add carry out", 7, 8'hFF, 8'h03, 1, 0, 0, 0);
    runOp("R8 add neg ovf", 7, 8'h80, 8'h00, 1, 0, 0, 0); // byte 0x80 -> 0x00, C=1, V=1
  endtask

  task automatic tSub;
    runOp("R9 sub no borrow", 8, 8'h50, 8'h0F, 1, 1, 0, 0);
    runOp("R9 sub borrow in", 8, 8'h50, 8'h0F, 0, 0, 0, 0);
    runOp("R9 inc wrap", 8, 8'h05, 8'hFF, 1, 0, 0, 0);
    runOp("R9 sub ovf", 8, 8'h80, 8'h00, 1, 0, 0, 0);
    runOp("R9 sub underflow", 8, 8'h00, 8'h00, 1, 0, 0, 0);
  endtask

  task automatic tPass;
    for (int op = 9; op < 16; op++) begin
      runOp("R10 unsupported", op, op * 17, 8'hA5 ^ op, op & 1, (op >> 1) & 1, (op >> 2) & 1, (op >> 3) & 1);
    end
  endtask

  task automatic tHold;
    logic [19:0] snap;
    runOp("R11 setup", 7, 8'h12, 8'h34, 1, 0, 0, 0);
    snap = {outByte, outAcc, outCarry, outOvf, outNeg, outZero};
    opSel = 4'd2; operand = 8'hFF; accIn = 8'h00; carryIn = 1'b0; ovfIn = 1'b1;
    negIn = 1'b1; zeroIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 hold outputs", {outByte, outAcc, outCarry, outOvf, outNeg, outZero}, snap);
    check("R11 no strobe", outValid, 0);
  endtask

  initial begin
    tReset();
    tShifts();
    tRotates();
    tLogic();
    tAdd();
    tSub();
    tPass();
    tHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule